// File: doc/BRIEF.md
# Two-Wire Bus Segment Join Controller

This block decides when a plug-in card's two-wire bus segment may be tied to the backplane segment. It holds everything apart while the supply-good input is low. Once the supply is good and the enable level is high, it watches both segments for a finished transaction. It then raises `connect_o` and pulls the active-low ready flag down. A finished transaction means one of two things: both segments idle, or a stop condition on one segment while the other segment is idle.

The precharge request stays on from reset until the first join and does not return unless supply lockout occurs again. The rise-time accelerators are allowed only while the segments are joined. They are held off while the external recovery sequencer reports a stuck-bus fault, which covers its automatic clocking. The line drivers, the precharge source and the analogue thresholds sit outside this block. It sees only sampled logic levels.

Top module: `bus_join_ctrl`

## Requirements
- R1: While `supply_ok_i` is low, `connect_o` is low and all bus activity is ignored. On the first clock edge with supply low, the controller returns to lockout and `precharge_o` goes high.
- R2: A join needs one of two conditions: both sides idle, or a stop on one side while the other side is idle. Neither a stop on one side while the other side is busy nor a busy side on its own ever joins.
- R3: A side is idle once its SDA and SCL have both read high for `IDLE_CYCLES` consecutive synchronized samples. A low on either line restarts that count. With the other side already idle, `connect_o` rises on the `IDLE_CYCLES+3`-th rising clock edge after both lines of the last busy side return high, and not on the edge before.
- R4: A stop is a rising SDA edge while SCL reads high, seen after a two-flop synchronizer. With the other side idle, `connect_o` rises on the third rising edge after SDA rises, and not on the second.
- R5: `precharge_o` is high from reset until the first join. It then stays low through enable toggles and stuck faults, and only a lockout sets it again.
- R6: `enable_i` low forces `connect_o` low and `ready_no` high in the same cycle, combinationally, and no join occurs while it stays low.
- R7: After `enable_i` returns high, the join waits for a fresh qualification per R2. With both sides already idle, the join follows one clock edge after the return to wait.
- R8: `ready_no` is low exactly when `connect_o` is high. It reads high during lockout, before qualification, with enable low and during a stuck fault.
- R9: `stuck_fault_i` high drops `connect_o` and `accel_en_o` in the same cycle. Once it clears, the controller requalifies, and with both sides idle it joins on the second edge.
- R10: `accel_en_o` is high only while `connect_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above lockout threshold |
| enable_i | input | 1 | Join permission level |
| stuck_fault_i | input | 1 | Stuck-bus fault from recovery sequencer (covers recovery clocking) |
| card_sda_i | input | 1 | Card-side SDA level, asynchronous |
| card_scl_i | input | 1 | Card-side SCL level, asynchronous |
| bp_sda_i | input | 1 | Backplane-side SDA level, asynchronous |
| bp_scl_i | input | 1 | Backplane-side SCL level, asynchronous |
| connect_o | output | 1 | Join the two segments |
| precharge_o | output | 1 | Precharge request |
| accel_en_o | output | 1 | Rise-time accelerators allowed |
| ready_no | output | 1 | Active-low joined indication |

## Verification
The qualification is exercised with every static level pattern that matters: all four lines high, each line low alone, one side fully low, and everything low. Only the all-high case should join, so these patterns show whether each line feeds its side's idle test. A stop on the card side is driven while the backplane is idle, and again while the backplane SCL is held low. The first case must join within three edges, which separates the stop path from the much slower idle path. The second must not join, which shows that a stop alone is not enough. Exact edge counts after an idle release, plus enable, fault and supply toggles, separate the registered paths from the combinational gating.

// File: rtl/bjc_pkg.sv
package bjc_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned LINES_PER_SIDE = 2;

  typedef enum logic [1:0] {
    S_LOCK  = 2'd0,
    S_WAIT  = 2'd1,
    S_CONN  = 2'd2,
    S_FAULT = 2'd3
  } join_state_e;
endpackage

// File: rtl/bjc_sync.sv
module bjc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {(STAGES*WIDTH){RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bjc_side_mon.sv
module bjc_side_mon #(
  parameter int unsigned IDLE_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic stop_o,
  output logic idle_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_CYCLES);

  logic          sda_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      sda_q <= sda_i;
      if (!sda_i || !scl_i)   cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stop_o = sda_i & ~sda_q & scl_i;
  assign idle_o = (cnt_q == CNT_MAX);

  // any low line clears idle on the next edge
  p_idle_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sda_i || !scl_i) |=> !idle_o);

  // idle is only reached by counting up one step at a time
  p_idle_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(sda_i && scl_i));
endmodule

// File: rtl/bus_join_ctrl.sv
module bus_join_ctrl
  import bjc_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic enable_i,
  input  logic stuck_fault_i,
  input  logic card_sda_i,
  input  logic card_scl_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  output logic connect_o,
  output logic precharge_o,
  output logic accel_en_o,
  output logic ready_no
);
  localparam int unsigned NLINES = NUM_SIDES * LINES_PER_SIDE;

  // line order per side: {scl, sda}; side 0 = card, side 1 = backplane
  logic [NLINES-1:0]    lines_raw, lines_s;
  logic [NUM_SIDES-1:0] side_stop, side_idle;
  logic                 qualified;
  join_state_e          state_q, state_d;
  logic                 precharge_q;

  assign lines_raw = {bp_scl_i, bp_sda_i, card_scl_i, card_sda_i};

  bjc_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lines_raw),
    .q_o   (lines_s)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    bjc_side_mon #(.IDLE_CYCLES(IDLE_CYCLES)) u_mon (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sda_i (lines_s[s*LINES_PER_SIDE]),
      .scl_i (lines_s[s*LINES_PER_SIDE+1]),
      .stop_o(side_stop[s]),
      .idle_o(side_idle[s])
    );
  end

  assign qualified = (side_idle[0] & side_idle[1]) |
                     (side_stop[0] & side_idle[1]) |
                     (side_stop[1] & side_idle[0]);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_LOCK:  state_d = S_WAIT;
      S_WAIT:  if (stuck_fault_i)              state_d = S_FAULT;
               else if (enable_i && qualified) state_d = S_CONN;
      S_CONN:  if (stuck_fault_i)              state_d = S_FAULT;
               else if (!enable_i)             state_d = S_WAIT;
      S_FAULT: if (!stuck_fault_i)             state_d = S_WAIT;
      default: state_d = S_LOCK;
    endcase
    if (!supply_ok_i) state_d = S_LOCK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_LOCK;
      precharge_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (!supply_ok_i)                            precharge_q <= 1'b1;
      else if (state_q == S_WAIT && state_d == S_CONN) precharge_q <= 1'b0;
    end
  end

  // enable, fault and supply cut the join without waiting for an edge
  assign connect_o   = (state_q == S_CONN) & enable_i & supply_ok_i & ~stuck_fault_i;
  assign accel_en_o  = connect_o;
  assign ready_no    = ~connect_o;
  assign precharge_o = precharge_q;

  p_lockout_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !connect_o);

  p_lockout_precharge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> precharge_o);

  p_join_needs_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |=> (state_q != S_CONN) || $past(|side_idle));

  p_precharge_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && !precharge_o) |=> !precharge_o);

  p_enable_cut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (ready_no && !connect_o));

  p_ready_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_no != connect_o);

  p_fault_accel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_fault_i |-> (!accel_en_o && !connect_o));

  p_accel_joined_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accel_en_o |-> connect_o);
endmodule

// File: tb/bus_join_ctrl_bench.sv
module bus_join_ctrl_bench;
  localparam int unsigned N = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, enable = 1'b0, stuck = 1'b0;
  logic c_sda = 1'b1, c_scl = 1'b1, b_sda = 1'b1, b_scl = 1'b1;
  logic connect, precharge, accel, ready_n;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bus_join_ctrl #(.IDLE_CYCLES(N)) u_bus_join_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .supply_ok_i  (supply_ok),
    .enable_i     (enable),
    .stuck_fault_i(stuck),
    .card_sda_i   (c_sda),
    .card_scl_i   (c_scl),
    .bp_sda_i     (b_sda),
    .bp_scl_i     (b_scl),
    .connect_o    (connect),
    .precharge_o  (precharge),
    .accel_en_o   (accel),
    .ready_no     (ready_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // {card_sda, card_scl, bp_sda, bp_scl, expect_join}
  localparam logic [4:0] VEC [7] = '{
    5'b1111_1, 5'b0111_0, 5'b1011_0, 5'b1101_0,
    5'b1110_0, 5'b0000_0, 5'b1100_0
  };

  initial begin : watchdog
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    tick(2);
    // reset state, R1/R5/R8
    check("R8", "reset ready_n", ready_n, 1'b1);
    check("R5", "reset precharge", precharge, 1'b1);
    rst_n = 1'b1;
    enable = 1'b1;
    tick(2 * N);
    check("R1", "lockout connect", connect, 1'b0);
    check("R1", "lockout precharge", precharge, 1'b1);
    check("R10", "lockout accel", accel, 1'b0);

    supply_ok = 1'b1;
    tick(1);
    check("R2", "wait state connect", connect, 1'b0);
    tick(1);
    check("R2", "both idle join", connect, 1'b1);
    check("R5", "precharge after join", precharge, 1'b0);
    check("R8", "ready_n joined", ready_n, 1'b0);
    check("R10", "accel joined", accel, 1'b1);

    // R6 / R7: immediate cut, then requalify
    enable = 1'b0;
    #1;
    check("R6", "enable low connect", connect, 1'b0);
    check("R6", "enable low ready_n", ready_n, 1'b1);
    tick(1);
    enable = 1'b1;
    #1;
    check("R7", "enable back before edge", connect, 1'b0);
    tick(1);
    check("R7", "rejoin after requalify", connect, 1'b1);
    check("R5", "precharge stays low", precharge, 1'b0);

    // R2 pattern table
    for (int i = 0; i < 7; i++) begin
      enable = 1'b0;
      {c_sda, c_scl, b_sda, b_scl} = VEC[i][4:1];
      tick(N + 6);
      check("R6", "no join while enable low", connect, 1'b0);
      enable = 1'b1;
      tick(2);
      check("R2", $sformatf("pattern %0d join", i), connect, VEC[i][0]);
      check("R8", $sformatf("pattern %0d ready_n", i), ready_n, ~VEC[i][0]);
    end

    // R3: exact idle timing after card side release
    enable = 1'b0;
    {c_sda, c_scl, b_sda, b_scl} = 4'b0011;
    tick(4);
    {c_sda, c_scl} = 2'b11;
    enable = 1'b1;
    tick(N + 2);
    check("R3", "idle edge N+2", connect, 1'b0);
    tick(1);
    check("R3", "idle edge N+3", connect, 1'b1);

    // R4: stop on card side, backplane idle
    enable = 1'b0;
    {c_sda, c_scl} = 2'b00;
    tick(4);
    c_scl = 1'b1;
    tick(4);
    enable = 1'b1;
    c_sda = 1'b1;
    tick(2);
    check("R4", "stop edge 2", connect, 1'b0);
    tick(1);
    check("R4", "stop edge 3", connect, 1'b1);

    // R2: stop on card side while backplane busy
    enable = 1'b0;
    b_scl = 1'b0;
    {c_sda, c_scl} = 2'b00;
    tick(4);
    c_scl = 1'b1;
    tick(4);
    enable = 1'b1;
    c_sda = 1'b1;
    tick(8);
    check("R2", "stop with other side busy", connect, 1'b0);
    b_scl = 1'b1;
    tick(N + 5);
    check("R2", "join after backplane idle", connect, 1'b1);

    // R9: stuck fault
    stuck = 1'b1;
    #1;
    check("R9", "fault connect", connect, 1'b0);
    check("R9", "fault accel", accel, 1'b0);
    check("R8", "fault ready_n", ready_n, 1'b1);
    tick(3);
    stuck = 1'b0;
    tick(1);
    check("R9", "fault cleared edge 1", connect, 1'b0);
    tick(1);
    check("R9", "fault cleared edge 2", connect, 1'b1);
    check("R5", "precharge after fault", precharge, 1'b0);

    // R1/R5: supply drop re-arms precharge
    supply_ok = 1'b0;
    #1;
    check("R1", "supply drop connect", connect, 1'b0);
    tick(1);
    check("R5", "precharge re-armed", precharge, 1'b1);
    tick(3);
    supply_ok = 1'b1;
    tick(2);
    check("R1", "join after lockout exit", connect, 1'b1);
    check("R5", "precharge cleared again", precharge, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule